// File: doc/BRIEF.md
# Shared-Address Read/Write Command Arbiter

This block sits at the command side of a memory with separate read and write ports that share one address bus. On every rising edge of the command clock it samples two active-low port selects together with the shared address, and it decides whether the edge starts a read burst, a write burst or nothing. A started burst occupies its port for two cycles. The block reports each start as a one-cycle pulse with the captured address, and it shows a busy flag per port for the whole burst.

A port cannot start again in the cycle directly after its own start. A request that arrives in that cycle is dropped. When both ports are eligible on the same edge, the winner depends on what started on the previous edge. The read port wins unless a read started on the previous edge. So if both selects are held low from idle, the block produces strictly alternating starts, beginning with a read. A losing request is discarded, not queued. The memory array and the data paths sit outside this block.

Top module: `dualport_cmd_arbiter`

## Requirements
- R1: Both selects are active low (0 = request) and are sampled only on the rising clock edge. An accepted request raises its start output for exactly the one cycle that follows that edge.
- R2: While reset is low, and in the first cycle after it is released, both start outputs and both busy outputs are 0, even if the selects are held low during reset.
- R3: A read request sampled on the edge right after a read start is ignored. A read request on the edge after that is accepted again.
- R4: A write request sampled on the edge right after a write start is ignored. A write request on the edge after that is accepted again.
- R5: If both selects are low on an edge and neither port started on the previous edge, the read port starts and the write request is dropped.
- R6: If both selects are low on an edge and a read started on the previous edge, the write port starts.
- R7: If both selects are low on an edge and a write started on the previous edge, the read port starts.
- R8: If both selects are held low continuously from an idle state, the starts alternate read, write, read, write, with one start per cycle.
- R9: A port's busy output is 1 in the start cycle and in the cycle after it. It stays 1 for the second cycle even if the select is released.
- R10: The start cycle presents, on the port's address output, the address sampled on the accepting edge. That output keeps its value until the port's next start, including while the other port starts.
- R11: A losing request is not remembered. If the selects are released after a loss, the losing port never starts.
- R12: The read start and the write start are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_sel_n | input | 1 | Read request, active low |
| wr_sel_n | input | 1 | Write request, active low |
| cmd_addr | input | AW | Shared address bus |
| rd_start | output | 1 | One-cycle pulse: read burst begins |
| rd_addr | output | AW | Address of the latest read burst |
| rd_busy | output | 1 | Read burst in progress |
| wr_start | output | 1 | One-cycle pulse: write burst begins |
| wr_addr | output | AW | Address of the latest write burst |
| wr_busy | output | 1 | Write burst in progress |

## Verification
The bench drives several input patterns. A lone read and a lone write show the start timing, the address capture and the two-cycle busy span. A select held low for several cycles on one port shows that the second request is dropped and the third is accepted. Simultaneous requests from idle, after a read and after a write tell apart the three priority cases. Holding both selects low shows the read-first alternation. A single simultaneous pulse followed by release shows that the loser is not queued. Every cycle is also compared with a cycle-level reference model kept inside the bench.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_RD   = 2'd1,
    GR_WR   = 2'd2
  } grant_e;

  localparam int unsigned PORT_RD = 0;
  localparam int unsigned PORT_WR = 1;
  localparam int unsigned NPORTS  = 2;

  // Priority between two eligible ports, decided from last edge's starts.
  function automatic grant_e pick_grant(input logic rd_ok, input logic wr_ok,
                                        input logic rd_last, input logic wr_last);
    grant_e g;
    if (rd_ok && wr_ok) begin
      if (rd_last && !wr_last) g = GR_WR;
      else                     g = GR_RD;
    end else if (rd_ok) begin
      g = GR_RD;
    end else if (wr_ok) begin
      g = GR_WR;
    end else begin
      g = GR_NONE;
    end
    return g;
  endfunction

  // A port is locked out while more than its final beat remains.
  function automatic logic beats_lock(input int unsigned remaining);
    return remaining > 1;
  endfunction

endpackage

// File: rtl/arb_port_lane.sv
module arb_port_lane #(
  parameter int unsigned AW    = 8,
  parameter int unsigned BURST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          win,
  input  logic [AW-1:0] addr_in,
  output logic          eligible,
  output logic          start,
  output logic          busy,
  output logic [AW-1:0] addr_q
);
  import arb_pkg::*;

  localparam int unsigned CW = $clog2(BURST + 1);

  logic [CW-1:0] remain_q;
  logic          start_q;
  logic [AW-1:0] addr_r;
  logic          locked;

  assign locked   = beats_lock(int'(remain_q));
  assign eligible = req && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      start_q  <= 1'b0;
      addr_r   <= '0;
    end else begin
      start_q <= win;
      if (win) begin
        remain_q <= CW'(BURST);
        addr_r   <= addr_in;
      end else if (remain_q != '0) begin
        remain_q <= remain_q - CW'(1);
      end
    end
  end

  assign start  = start_q;
  assign busy   = (remain_q != '0);
  assign addr_q = addr_r;

endmodule

// File: rtl/arb_core.sv
module arb_core (
  input  logic             rd_ok,
  input  logic             wr_ok,
  input  logic             rd_last,
  input  logic             wr_last,
  output arb_pkg::grant_e  grant
);
  import arb_pkg::*;

  always_comb begin
    grant = pick_grant(rd_ok, wr_ok, rd_last, wr_last);
  end

endmodule

// File: rtl/dualport_cmd_arbiter.sv
module dualport_cmd_arbiter #(
  parameter int unsigned AW    = 8,
  parameter int unsigned BURST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] cmd_addr,
  output logic          rd_start,
  output logic [AW-1:0] rd_addr,
  output logic          rd_busy,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr,
  output logic          wr_busy
);
  import arb_pkg::*;

  logic [NPORTS-1:0]   port_req;
  logic [NPORTS-1:0]   port_elig;
  logic [NPORTS-1:0]   port_win;
  logic [NPORTS-1:0]   port_start;
  logic [NPORTS-1:0]   port_busy;
  logic [AW-1:0]       port_addr [NPORTS];
  grant_e              grant;

  // Named internal events for the checker
  logic rd_elig;
  logic wr_elig;

  assign port_req[PORT_RD] = ~rd_sel_n;
  assign port_req[PORT_WR] = ~wr_sel_n;

  arb_core u_core (
    .rd_ok   (port_elig[PORT_RD]),
    .wr_ok   (port_elig[PORT_WR]),
    .rd_last (port_start[PORT_RD]),
    .wr_last (port_start[PORT_WR]),
    .grant   (grant)
  );

  assign port_win[PORT_RD] = (grant == GR_RD);
  assign port_win[PORT_WR] = (grant == GR_WR);

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    arb_port_lane #(.AW(AW), .BURST(BURST)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (port_req[p]),
      .win      (port_win[p]),
      .addr_in  (cmd_addr),
      .eligible (port_elig[p]),
      .start    (port_start[p]),
      .busy     (port_busy[p]),
      .addr_q   (port_addr[p])
    );
  end

  assign rd_elig  = port_elig[PORT_RD];
  assign wr_elig  = port_elig[PORT_WR];

  assign rd_start = port_start[PORT_RD];
  assign wr_start = port_start[PORT_WR];
  assign rd_busy  = port_busy[PORT_RD];
  assign wr_busy  = port_busy[PORT_WR];
  assign rd_addr  = port_addr[PORT_RD];
  assign wr_addr  = port_addr[PORT_WR];

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_sel_n,
  input logic          wr_sel_n,
  input logic [AW-1:0] cmd_addr,
  input logic          rd_start,
  input logic          wr_start,
  input logic          rd_busy,
  input logic          wr_busy,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] wr_addr,
  input logic          rd_elig,
  input logic          wr_elig
);

  p_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> $past(!rd_sel_n));

  p_rd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  p_wr_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  p_rd_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_elig && wr_elig && !rd_start) |=> (rd_start && !wr_start));

  p_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_sel_n && !wr_sel_n) |=> wr_start);

  p_rd_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> rd_busy);

  p_wr_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> wr_busy);

  p_rd_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> (rd_addr == $past(cmd_addr)));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_start |-> $stable(rd_addr));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_start |-> $stable(wr_addr));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start && wr_start));

endmodule

bind dualport_cmd_arbiter arb_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_sel_n (rd_sel_n),
  .wr_sel_n (wr_sel_n),
  .cmd_addr (cmd_addr),
  .rd_start (rd_start),
  .wr_start (wr_start),
  .rd_busy  (rd_busy),
  .wr_busy  (wr_busy),
  .rd_addr  (rd_addr),
  .wr_addr  (wr_addr),
  .rd_elig  (rd_elig),
  .wr_elig  (wr_elig)
);

// File: tb/dualport_cmd_arbiter_tb.sv
module dualport_cmd_arbiter_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] cmd_addr = '0;
  logic          rd_start, rd_busy, wr_start, wr_busy;
  logic [AW-1:0] rd_addr, wr_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dualport_cmd_arbiter #(.AW(AW), .BURST(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .cmd_addr(cmd_addr), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_busy(rd_busy), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_busy(wr_busy)
  );

  // Reference model: last-start flags and second-beat flags per port
  logic          m_rs = 0, m_ws = 0, m_r2 = 0, m_w2 = 0;
  logic [AW-1:0] m_ra = '0, m_wa = '0;
  always @(posedge clk) begin
    logic want_r, want_w, take_r, take_w;
    if (!rst_n) begin
      m_rs = 0; m_ws = 0; m_r2 = 0; m_w2 = 0; m_ra = '0; m_wa = '0;
    end else begin
      want_r = !rd_sel_n && !m_rs;
      want_w = !wr_sel_n && !m_ws;
      take_r = want_r && !(want_w && m_rs);
      take_w = want_w && !take_r;
      m_r2 = m_rs; m_w2 = m_ws;
      m_rs = take_r; m_ws = take_w;
      if (take_r) m_ra = cmd_addr;
      if (take_w) m_wa = cmd_addr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_cmp();
    chk("R1 model rd_start", 32'(rd_start), 32'(m_rs));
    chk("R12 model wr_start", 32'(wr_start), 32'(m_ws));
    chk("R9 model rd_busy", 32'(rd_busy), 32'(m_rs | m_r2));
    chk("R9 model wr_busy", 32'(wr_busy), 32'(m_ws | m_w2));
    chk("R10 model rd_addr", 32'(rd_addr), 32'(m_ra));
    chk("R10 model wr_addr", 32'(wr_addr), 32'(m_wa));
  endtask

  // Drive at a falling edge, pass one rising edge, observe at the next fall
  task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a);
    rd_sel_n = rn; wr_sel_n = wn; cmd_addr = a;
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0);
  endtask

  task automatic t_reset();
    rd_sel_n = 1'b0; wr_sel_n = 1'b0; cmd_addr = 8'hAA;
    repeat (3) @(negedge clk);
    chk("R2 rd_start in reset", 32'(rd_start), 0);
    chk("R2 wr_start in reset", 32'(wr_start), 0);
    chk("R2 busy in reset", 32'({rd_busy, wr_busy}), 0);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    rst_n = 1'b1;
    step(1'b1, 1'b1, '0);
    chk("R2 after release", 32'({rd_start, wr_start, rd_busy, wr_busy}), 0);
  endtask

  task automatic t_single_read();
    step(1'b0, 1'b1, 8'h1A);
    chk("R1 rd_start pulse", 32'(rd_start), 1);
    chk("R10 rd_addr", 32'(rd_addr), 32'h1A);
    chk("R9 rd_busy beat1", 32'(rd_busy), 1);
    step(1'b1, 1'b1, 8'h00);
    chk("R1 rd_start one cycle", 32'(rd_start), 0);
    chk("R9 rd_busy beat2 after release", 32'(rd_busy), 1);
    step(1'b1, 1'b1, 8'h00);
    chk("R9 rd_busy ends", 32'(rd_busy), 0);
  endtask

  task automatic t_read_b2b();
    step(1'b0, 1'b1, 8'h21);
    chk("R3 first read", 32'(rd_start), 1);
    step(1'b0, 1'b1, 8'h22);
    chk("R3 back-to-back read ignored", 32'(rd_start), 0);
    chk("R3 addr kept", 32'(rd_addr), 32'h21);
    step(1'b0, 1'b1, 8'h23);
    chk("R3 third read accepted", 32'(rd_start), 1);
    chk("R3 addr new", 32'(rd_addr), 32'h23);
    idle(2);
  endtask

  task automatic t_write_b2b();
    step(1'b1, 1'b0, 8'h31);
    chk("R4 first write", 32'(wr_start), 1);
    chk("R9 wr_busy beat1", 32'(wr_busy), 1);
    step(1'b1, 1'b0, 8'h32);
    chk("R4 back-to-back write ignored", 32'(wr_start), 0);
    chk("R9 wr_busy beat2", 32'(wr_busy), 1);
    step(1'b1, 1'b0, 8'h33);
    chk("R4 third write accepted", 32'(wr_start), 1);
    chk("R10 wr_addr", 32'(wr_addr), 32'h33);
    chk("R10 rd_addr untouched by write", 32'(rd_addr), 32'h23);
    idle(2);
  endtask

  task automatic t_both_idle();
    step(1'b0, 1'b0, 8'h44);
    chk("R5 read wins from idle", 32'(rd_start), 1);
    chk("R5 write loses", 32'(wr_start), 0);
    step(1'b1, 1'b1, 8'h00);
    chk("R11 loser not queued", 32'(wr_start), 0);
    step(1'b1, 1'b1, 8'h00);
    chk("R11 still no write", 32'(wr_start), 0);
    chk("R11 wr_addr unchanged", 32'(wr_addr), 32'h33);
  endtask

  task automatic t_after_write();
    step(1'b1, 1'b0, 8'h55);
    chk("R7 write start", 32'(wr_start), 1);
    step(1'b0, 1'b0, 8'h56);
    chk("R7 read wins after write", 32'(rd_start), 1);
    chk("R7 write not started", 32'(wr_start), 0);
    idle(2);
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, AW'(8'h60 + i));
      if (i % 2 == 0) begin
        chk("R8 read slot", 32'({rd_start, wr_start}), 32'b10);
        chk("R8 read addr", 32'(rd_addr), 32'(8'h60 + i));
        if (i > 0) chk("R7 read after write", 32'(rd_start), 1);
      end else begin
        chk("R8 write slot", 32'({rd_start, wr_start}), 32'b01);
        chk("R6 write after read", 32'(wr_start), 1);
        chk("R10 write addr", 32'(wr_addr), 32'(8'h60 + i));
      end
      chk("R12 never both", 32'(rd_start & wr_start), 0);
    end
    idle(3);
  endtask

  bit done = 0;

  initial begin
    @(negedge clk);
    t_reset();
    t_single_read();
    t_read_b2b();
    t_write_b2b();
    t_both_idle();
    t_after_write();
    t_alternate();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule